// File: doc/BRIEF.md
# Two-Channel Bus Breakpoint Comparator

This debug block watches processor bus cycles and raises a break request when a cycle meets the conditions programmed for one of its two channels, A and B. Four buses are monitored: logical, internal, X-memory and Y-memory. Each bus carries its own valid strobe, address space identifier (ASID), address, data, cycle type, direction and operand size. Each channel uses a 2-bit select to pick one of these buses. It then compares a 40-bit key, made of the 8-bit ASID and the 32-bit address, against its programmed value. Every address bit has its own mask bit, and one control bit makes the whole ASID either compared or ignored. The channel can also require a given cycle type, direction or operand size. Channel B has one more condition: a masked 32-bit compare against the data bus paired with its selected address bus.

A channel hit sets a sticky match flag. Software clears the flags with a clear strobe. In independent mode, a hit on either channel produces a one-cycle break request. In sequential mode, a small state machine with two states, IDLE and ARMED, orders the channels:
- **ARM** (IDLE to ARMED): taken on a channel A hit.
- **FIRE** (ARMED to IDLE): taken on a channel B hit that has no channel A hit in the same cycle, while breaks are enabled. This transition issues the request.
- **DISARM** (any state to IDLE): taken on the clear strobe or when sequential mode is switched off.

Any other combination keeps the current state. All results are registered: a bus cycle presented before clock edge N is reflected on the outputs just after edge N.

Top module: `brk_cmp_top`

## Requirements
- R1: After reset, `brk_req`, `match_a` and `match_b` are 0.
- R2: A channel hits only if the address bits not masked (mask bit 1 = ignore) equal the programmed address. When the channel's ASID enable is 1, the bus ASID must also equal the programmed ASID; when it is 0, the ASID is ignored.
- R3: A channel watches only the bus whose index is in its select field (0 logical, 1 internal, 2 X-memory, 3 Y-memory). It hits only when that bus's valid strobe is 1.
- R4: Cycle type select: 1 = fetch only, 2 = data only, 0 or 3 = any. Direction select: 1 = read only, 2 = write only, 0 or 3 = any. Size select: 0 = any, 1 = byte, 2 = word, 3 = longword. The bus size codes are 0 = byte, 1 = word, 2 = longword.
- R5: Channel B also requires the data bits not masked (mask bit 1 = ignore) to equal its programmed data. Channel A ignores bus data.
- R6: `match_a` and `match_b` rise one clock after a hit and stay set until `clr`. A `clr` cycle leaves both flags at 0, even if that cycle also holds a hit.
- R7: In independent mode (`seq_mode`=0) with `brk_en`=1, every cycle with a hit on either channel gives a one-cycle `brk_req` one clock later.
- R8: In sequential mode, `brk_req` is issued only for a channel B hit that has no channel A hit in the same cycle, and only after an earlier channel A hit. A cycle where both channels hit arms or keeps the sequence armed but never completes it.
- R9: With `brk_en`=0, `brk_req` stays 0. Flags still update, and an armed sequence stays armed.
- R10: `clr` suppresses the request for its own cycle and disarms the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_vld | input | 4 | Per-bus cycle valid strobe |
| bus_asid | input | 32 | Per-bus ASID, 8 bits each, bus i at [8i+7:8i] |
| bus_addr | input | 128 | Per-bus address, 32 bits each |
| bus_data | input | 128 | Per-bus data, 32 bits each |
| bus_fetch | input | 4 | Per-bus 1 = instruction fetch, 0 = data access |
| bus_wr | input | 4 | Per-bus 1 = write, 0 = read |
| bus_size | input | 8 | Per-bus size code, 2 bits each |
| a_bus_sel | input | 2 | Channel A bus select |
| a_asid | input | 8 | Channel A ASID |
| a_asid_en | input | 1 | Channel A ASID compare enable |
| a_addr | input | 32 | Channel A address |
| a_addr_mask | input | 32 | Channel A address ignore mask |
| a_type_sel | input | 2 | Channel A cycle type select |
| a_dir_sel | input | 2 | Channel A direction select |
| a_size_sel | input | 2 | Channel A size select |
| b_bus_sel | input | 2 | Channel B bus select |
| b_asid | input | 8 | Channel B ASID |
| b_asid_en | input | 1 | Channel B ASID compare enable |
| b_addr | input | 32 | Channel B address |
| b_addr_mask | input | 32 | Channel B address ignore mask |
| b_type_sel | input | 2 | Channel B cycle type select |
| b_dir_sel | input | 2 | Channel B direction select |
| b_size_sel | input | 2 | Channel B size select |
| b_data | input | 32 | Channel B data value |
| b_data_mask | input | 32 | Channel B data ignore mask |
| seq_mode | input | 1 | 1 = sequential A-then-B, 0 = independent |
| brk_en | input | 1 | Break request enable |
| clr | input | 1 | Clears flags and disarms sequence |
| brk_req | output | 1 | Break request pulse |
| match_a | output | 1 | Sticky channel A match flag |
| match_b | output | 1 | Sticky channel B match flag |

## Verification
The bench targets the cycle in which both channels hit at once, both from IDLE and while ARMED. A design that treats that cycle as completing the sequence would fire a request too early. It also checks that a channel B hit without a prior channel A hit gives no request, and that a clear between the A hit and the B hit prevents the request; a design that disarms only on FIRE would fire there. Mask handling is probed by moving an address across a masked page boundary and flipping one data bit. Bus select is probed by placing the matching address on a bus the channel does not watch, which a wrong mux would accept. Disabled breaks must still set flags and keep the sequence armed.

// File: rtl/brk_pkg.sv
package brk_pkg;
    localparam int ASID_W = 8;
    localparam int ADDR_W = 32;
    localparam int DATA_W = 32;
    localparam int SIZE_W = 2;

    typedef struct packed {
        logic              vld;
        logic [ASID_W-1:0] asid;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic              fetch;
        logic              wr;
        logic [SIZE_W-1:0] size;
    } bus_t;

    typedef enum logic {
        ST_IDLE,
        ST_ARMED
    } seq_st_e;
endpackage

// File: rtl/brk_bus_sel.sv
module brk_bus_sel #(
    parameter int NBUS  = 4,
    parameter int SEL_W = $clog2(NBUS)
) (
    input  logic [NBUS-1:0]                 bus_vld,
    input  logic [NBUS*brk_pkg::ASID_W-1:0] bus_asid,
    input  logic [NBUS*brk_pkg::ADDR_W-1:0] bus_addr,
    input  logic [NBUS*brk_pkg::DATA_W-1:0] bus_data,
    input  logic [NBUS-1:0]                 bus_fetch,
    input  logic [NBUS-1:0]                 bus_wr,
    input  logic [NBUS*brk_pkg::SIZE_W-1:0] bus_size,
    input  logic [SEL_W-1:0]                sel,
    output brk_pkg::bus_t                   picked
);
    import brk_pkg::*;

    bus_t lanes [NBUS];

    for (genvar i = 0; i < NBUS; i++) begin : g_lane
        assign lanes[i].vld   = bus_vld[i];
        assign lanes[i].asid  = bus_asid[i*ASID_W +: ASID_W];
        assign lanes[i].addr  = bus_addr[i*ADDR_W +: ADDR_W];
        assign lanes[i].data  = bus_data[i*DATA_W +: DATA_W];
        assign lanes[i].fetch = bus_fetch[i];
        assign lanes[i].wr    = bus_wr[i];
        assign lanes[i].size  = bus_size[i*SIZE_W +: SIZE_W];
    end

    assign picked = lanes[sel];
endmodule

// File: rtl/brk_chan_cmp.sv
module brk_chan_cmp #(
    parameter bit HAS_DATA = 1'b0
) (
    input  brk_pkg::bus_t                 cyc,
    input  logic [brk_pkg::ASID_W-1:0]    cfg_asid,
    input  logic                          cfg_asid_en,
    input  logic [brk_pkg::ADDR_W-1:0]    cfg_addr,
    input  logic [brk_pkg::ADDR_W-1:0]    cfg_addr_mask,
    input  logic [1:0]                    cfg_type,
    input  logic [1:0]                    cfg_dir,
    input  logic [1:0]                    cfg_size,
    input  logic [brk_pkg::DATA_W-1:0]    cfg_data,
    input  logic [brk_pkg::DATA_W-1:0]    cfg_data_mask,
    output logic                          hit
);
    logic asid_ok, addr_ok, type_ok, dir_ok, size_ok, data_eq, data_ok;

    assign asid_ok = !cfg_asid_en || (cyc.asid == cfg_asid);
    assign addr_ok = ((cyc.addr ^ cfg_addr) & ~cfg_addr_mask) == '0;
    assign data_eq = ((cyc.data ^ cfg_data) & ~cfg_data_mask) == '0;

    always_comb begin
        unique case (cfg_type)
            2'd1:    type_ok = cyc.fetch;
            2'd2:    type_ok = !cyc.fetch;
            default: type_ok = 1'b1;
        endcase
        unique case (cfg_dir)
            2'd1:    dir_ok = !cyc.wr;
            2'd2:    dir_ok = cyc.wr;
            default: dir_ok = 1'b1;
        endcase
        size_ok = (cfg_size == 2'd0) || (cyc.size == (cfg_size - 2'd1));
    end

    if (HAS_DATA) begin : g_data
        assign data_ok = data_eq;
    end else begin : g_nodata
        assign data_ok = 1'b1;
    end

    assign hit = cyc.vld && asid_ok && addr_ok && type_ok && dir_ok && size_ok && data_ok;
endmodule

// File: rtl/brk_seq_fsm.sv
module brk_seq_fsm (
    input  logic clk,
    input  logic rst_n,
    input  logic hit_a,
    input  logic hit_b,
    input  logic seq_mode,
    input  logic brk_en,
    input  logic clr,
    output logic brk_req
);
    import brk_pkg::*;

    seq_st_e state, state_nx;
    logic    fire;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (seq_mode && hit_a) state_nx = ST_ARMED;
            ST_ARMED: if (!seq_mode || (hit_b && !hit_a && brk_en)) state_nx = ST_IDLE;
        endcase
        if (clr) state_nx = ST_IDLE;
    end

    assign fire = brk_en && !clr &&
                  (seq_mode ? (state == ST_ARMED && hit_b && !hit_a) : (hit_a || hit_b));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) brk_req <= 1'b0;
        else        brk_req <= fire;
    end
endmodule

// File: rtl/brk_cmp_top.sv
module brk_cmp_top #(
    parameter int NBUS  = 4,
    parameter int SEL_W = $clog2(NBUS)
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [NBUS-1:0]                 bus_vld,
    input  logic [NBUS*brk_pkg::ASID_W-1:0] bus_asid,
    input  logic [NBUS*brk_pkg::ADDR_W-1:0] bus_addr,
    input  logic [NBUS*brk_pkg::DATA_W-1:0] bus_data,
    input  logic [NBUS-1:0]                 bus_fetch,
    input  logic [NBUS-1:0]                 bus_wr,
    input  logic [NBUS*brk_pkg::SIZE_W-1:0] bus_size,
    input  logic [SEL_W-1:0]                a_bus_sel,
    input  logic [brk_pkg::ASID_W-1:0]      a_asid,
    input  logic                            a_asid_en,
    input  logic [brk_pkg::ADDR_W-1:0]      a_addr,
    input  logic [brk_pkg::ADDR_W-1:0]      a_addr_mask,
    input  logic [1:0]                      a_type_sel,
    input  logic [1:0]                      a_dir_sel,
    input  logic [1:0]                      a_size_sel,
    input  logic [SEL_W-1:0]                b_bus_sel,
    input  logic [brk_pkg::ASID_W-1:0]      b_asid,
    input  logic                            b_asid_en,
    input  logic [brk_pkg::ADDR_W-1:0]      b_addr,
    input  logic [brk_pkg::ADDR_W-1:0]      b_addr_mask,
    input  logic [1:0]                      b_type_sel,
    input  logic [1:0]                      b_dir_sel,
    input  logic [1:0]                      b_size_sel,
    input  logic [brk_pkg::DATA_W-1:0]      b_data,
    input  logic [brk_pkg::DATA_W-1:0]      b_data_mask,
    input  logic                            seq_mode,
    input  logic                            brk_en,
    input  logic                            clr,
    output logic                            brk_req,
    output logic                            match_a,
    output logic                            match_b
);
    import brk_pkg::*;

    bus_t cyc_a, cyc_b;
    logic hit_a, hit_b;

    brk_bus_sel #(.NBUS(NBUS), .SEL_W(SEL_W)) u_sel_a (
        .bus_vld(bus_vld), .bus_asid(bus_asid), .bus_addr(bus_addr), .bus_data(bus_data),
        .bus_fetch(bus_fetch), .bus_wr(bus_wr), .bus_size(bus_size),
        .sel(a_bus_sel), .picked(cyc_a)
    );

    brk_bus_sel #(.NBUS(NBUS), .SEL_W(SEL_W)) u_sel_b (
        .bus_vld(bus_vld), .bus_asid(bus_asid), .bus_addr(bus_addr), .bus_data(bus_data),
        .bus_fetch(bus_fetch), .bus_wr(bus_wr), .bus_size(bus_size),
        .sel(b_bus_sel), .picked(cyc_b)
    );

    brk_chan_cmp #(.HAS_DATA(1'b0)) u_cmp_a (
        .cyc(cyc_a), .cfg_asid(a_asid), .cfg_asid_en(a_asid_en),
        .cfg_addr(a_addr), .cfg_addr_mask(a_addr_mask),
        .cfg_type(a_type_sel), .cfg_dir(a_dir_sel), .cfg_size(a_size_sel),
        .cfg_data('0), .cfg_data_mask('1), .hit(hit_a)
    );

    brk_chan_cmp #(.HAS_DATA(1'b1)) u_cmp_b (
        .cyc(cyc_b), .cfg_asid(b_asid), .cfg_asid_en(b_asid_en),
        .cfg_addr(b_addr), .cfg_addr_mask(b_addr_mask),
        .cfg_type(b_type_sel), .cfg_dir(b_dir_sel), .cfg_size(b_size_sel),
        .cfg_data(b_data), .cfg_data_mask(b_data_mask), .hit(hit_b)
    );

    brk_seq_fsm u_seq (
        .clk(clk), .rst_n(rst_n), .hit_a(hit_a), .hit_b(hit_b),
        .seq_mode(seq_mode), .brk_en(brk_en), .clr(clr), .brk_req(brk_req)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            match_a <= 1'b0;
            match_b <= 1'b0;
        end else if (clr) begin
            match_a <= 1'b0;
            match_b <= 1'b0;
        end else begin
            match_a <= match_a | hit_a;
            match_b <= match_b | hit_b;
        end
    end
endmodule

// File: rtl/brk_cmp_chk.sv
module brk_cmp_chk (
    input logic clk,
    input logic rst_n,
    input logic brk_en,
    input logic seq_mode,
    input logic clr,
    input logic brk_req,
    input logic match_a,
    input logic match_b
);
    // R9
    req_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        brk_req |-> $past(brk_en));

    // R10
    req_blocked_by_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        brk_req |-> !$past(clr));

    // R6
    flag_a_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(match_a) && !$past(clr)) |-> match_a);

    // R6
    flag_b_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(match_b) && !$past(clr)) |-> match_b);

    // R6
    flags_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(clr) |-> (!match_a && !match_b));

    // R7
    req_has_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        brk_req |-> (match_a || match_b));

    // R8
    seq_needs_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (brk_req && $past(seq_mode)) |-> (match_a && match_b));
endmodule

bind brk_cmp_top brk_cmp_chk u_chk (.*);

// File: tb/sim_brk_cmp_top.sv
`timescale 1ns/1ps
module sim_brk_cmp_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic [3:0]   bus_vld = '0;
    logic [31:0]  bus_asid = '0;
    logic [127:0] bus_addr = '0;
    logic [127:0] bus_data = '0;
    logic [3:0]   bus_fetch = '0;
    logic [3:0]   bus_wr = '0;
    logic [7:0]   bus_size = '0;
    logic [1:0]   a_bus_sel = 2'd0, b_bus_sel = 2'd3;
    logic [7:0]   a_asid = 8'h12, b_asid = 8'h00;
    logic         a_asid_en = 1'b1, b_asid_en = 1'b0;
    logic [31:0]  a_addr = 32'h1000_0000, a_addr_mask = 32'h0000_0FFF;
    logic [31:0]  b_addr = 32'h2000_0040, b_addr_mask = 32'h0000_0000;
    logic [1:0]   a_type_sel = 0, a_dir_sel = 0, a_size_sel = 0;
    logic [1:0]   b_type_sel = 0, b_dir_sel = 0, b_size_sel = 0;
    logic [31:0]  b_data = 32'h0000_1234, b_data_mask = 32'hFFFF_0000;
    logic         seq_mode = 1'b0, brk_en = 1'b1, clr = 1'b0;
    logic         brk_req, match_a, match_b;

    brk_cmp_top u0 (.*);

    typedef struct {
        bit    req;
        bit    ma;
        bit    mb;
        string tag;
    } exp_t;

    exp_t q[$];
    int   n_chk = 0, n_fail = 0;
    bit   m_armed = 0, m_ma = 0, m_mb = 0;
    bit   done = 0;

    task automatic check(input string tag, input bit [2:0] act, input bit [2:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: {req,ma,mb} actual %b expected %b", tag, act, exp);
        end
    endtask

    // start of a driven cycle: bus idle, clear strobe low
    task automatic open_cyc();
        @(negedge clk);
        bus_vld = '0;
        clr = 1'b0;
    endtask

    task automatic put(input int i, input bit [7:0] asid, input bit [31:0] addr,
                       input bit [31:0] data, input bit fetch, input bit wr, input bit [1:0] size);
        bus_vld[i] = 1'b1;
        bus_asid[i*8 +: 8] = asid;
        bus_addr[i*32 +: 32] = addr;
        bus_data[i*32 +: 32] = data;
        bus_fetch[i] = fetch;
        bus_wr[i] = wr;
        bus_size[i*2 +: 2] = size;
    endtask

    // driver: expected channel hits given by the test, outputs from the requirement model
    task automatic cyc(input bit ha, input bit hb, input string tag);
        exp_t e;
        e.req = brk_en && !clr && (seq_mode ? (m_armed && hb && !ha) : (ha || hb));
        if (clr || !seq_mode) m_armed = 0;
        else if (m_armed)     m_armed = !(hb && !ha && brk_en);
        else                  m_armed = ha;
        m_ma = clr ? 0 : (m_ma | ha);
        m_mb = clr ? 0 : (m_mb | hb);
        e.ma = m_ma;
        e.mb = m_mb;
        e.tag = tag;
        q.push_back(e);
    endtask

    // monitor: compares just after each edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                check(e.tag, {brk_req, match_a, match_b}, {e.req, e.ma, e.mb});
            end
        end
    end

    initial begin
        #(5.0 * 20000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #12;
        check("R1 reset", {brk_req, match_a, match_b}, 3'b000);
        @(negedge clk);
        rst_n = 1'b1;

        // R2 address and ASID
        open_cyc(); put(0, 8'h12, 32'h1000_0ABC, 0, 0, 0, 2); cyc(1, 0, "R2 masked page hit R7");
        open_cyc(); clr = 1; cyc(0, 0, "R6 clear");
        open_cyc(); put(0, 8'h12, 32'h1000_1ABC, 0, 0, 0, 2); cyc(0, 0, "R2 unmasked bit miss");
        open_cyc(); put(0, 8'h13, 32'h1000_0000, 0, 0, 0, 2); cyc(0, 0, "R2 asid miss");
        open_cyc(); a_asid_en = 0; put(0, 8'h13, 32'h1000_0000, 0, 0, 0, 2); cyc(1, 0, "R2 asid ignored");
        open_cyc(); cyc(0, 0, "R6 sticky after hit");
        open_cyc(); clr = 1; put(0, 8'h13, 32'h1000_0000, 0, 0, 0, 2); cyc(1, 0, "R6 R10 clr beats hit");
        // R3 bus select
        open_cyc(); put(1, 8'h12, 32'h1000_0000, 0, 0, 0, 2); cyc(0, 0, "R3 other bus");
        open_cyc(); a_bus_sel = 1; put(1, 8'h12, 32'h1000_0000, 0, 0, 0, 2); cyc(1, 0, "R3 selected bus");
        open_cyc(); clr = 1; a_bus_sel = 0; cyc(0, 0, "R6 clear");
        // R4 type, direction, size
        open_cyc(); a_type_sel = 1; a_size_sel = 2; put(0, 0, 32'h1000_0004, 0, 1, 0, 1); cyc(1, 0, "R4 fetch word");
        open_cyc(); put(0, 0, 32'h1000_0004, 0, 0, 0, 1); cyc(0, 0, "R4 data vs fetch");
        open_cyc(); put(0, 0, 32'h1000_0004, 0, 1, 0, 0); cyc(0, 0, "R4 byte vs word");
        open_cyc(); a_type_sel = 2; a_size_sel = 3; a_dir_sel = 2; put(0, 0, 32'h1000_0004, 0, 0, 0, 2); cyc(0, 0, "R4 read vs write");
        open_cyc(); put(0, 0, 32'h1000_0004, 0, 0, 1, 2); cyc(1, 0, "R4 data write long");
        open_cyc(); clr = 1; a_type_sel = 0; a_size_sel = 0; a_dir_sel = 0; cyc(0, 0, "R6 clear");
        // R5 data on channel B, ignored on A
        open_cyc(); put(3, 0, 32'h2000_0040, 32'hABCD_1234, 0, 1, 2); cyc(0, 1, "R5 data masked hit");
        open_cyc(); put(3, 0, 32'h2000_0040, 32'hABCD_1235, 0, 1, 2); cyc(0, 0, "R5 data bit miss");
        open_cyc(); put(0, 8'h55, 32'h1000_0100, 32'hDEAD_BEEF, 0, 0, 2); cyc(1, 0, "R5 A ignores data");
        open_cyc(); clr = 1; cyc(0, 0, "R6 clear");
        // R9 disabled
        open_cyc(); brk_en = 0; put(0, 0, 32'h1000_0000, 0, 0, 0, 2); cyc(1, 0, "R9 no req flag set");
        open_cyc(); clr = 1; brk_en = 1; seq_mode = 1; cyc(0, 0, "R6 clear");
        // R8 sequential
        open_cyc(); put(3, 0, 32'h2000_0040, 32'h1234, 0, 0, 2); cyc(0, 1, "R8 B before A");
        open_cyc(); put(0, 0, 32'h1000_0000, 0, 0, 0, 2); cyc(1, 0, "R8 A arms");
        open_cyc(); put(3, 0, 32'h2000_0040, 32'h1234, 0, 0, 2); cyc(0, 1, "R8 B completes");
        open_cyc(); put(3, 0, 32'h2000_0040, 32'h1234, 0, 0, 2); cyc(0, 1, "R8 B after fire");
        open_cyc(); clr = 1; cyc(0, 0, "R6 clear");
        open_cyc(); put(0, 0, 32'h1000_0000, 0, 0, 0, 2); put(3, 0, 32'h2000_0040, 32'h1234, 0, 0, 2); cyc(1, 1, "R8 both from idle");
        open_cyc(); put(0, 0, 32'h1000_0000, 0, 0, 0, 2); put(3, 0, 32'h2000_0040, 32'h1234, 0, 0, 2); cyc(1, 1, "R8 both while armed");
        open_cyc(); brk_en = 0; put(3, 0, 32'h2000_0040, 32'h1234, 0, 0, 2); cyc(0, 1, "R9 armed B disabled");
        open_cyc(); brk_en = 1; put(3, 0, 32'h2000_0040, 32'h1234, 0, 0, 2); cyc(0, 1, "R8 R9 still armed");
        open_cyc(); put(0, 0, 32'h1000_0000, 0, 0, 0, 2); cyc(1, 0, "R10 arm");
        open_cyc(); clr = 1; cyc(0, 0, "R10 clear disarms");
        open_cyc(); put(3, 0, 32'h2000_0040, 32'h1234, 0, 0, 2); cyc(0, 1, "R10 B after clear");
        // R7 independent, back-to-back pulses
        open_cyc(); seq_mode = 0; put(3, 0, 32'h2000_0040, 32'h1234, 0, 0, 2); cyc(0, 1, "R7 B alone");
        open_cyc(); put(0, 0, 32'h1000_0000, 0, 0, 0, 2); cyc(1, 0, "R7 A alone");
        open_cyc(); cyc(0, 0, "R7 pulse ends");
        open_cyc();
        wait (q.size() == 0);
        #2;
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule